// File: doc/BRIEF.md
# Bus and System Control Register Bank

This block is the system control corner of an 8-bit microcontroller. It decodes four consecutive I/O register slots and holds the operating mode, the chip-enable pin selection, the stack page, the clock and oscillator controls and a pair of spare controls. It turns those settings into pin multiplexing for three shared chip-enable/DC pins and for a bus-request/bus-grant pin pair. It also exports the stack page, clock select and oscillator enable to the rest of the chip.

Two timing functions sit beside the registers. A wait-state counter stretches each external bus cycle by an even number of states chosen by a 3-bit code, holding a ready line low meanwhile. An interrupt gate keeps every interrupt request, the non-maskable one included, away from the CPU until software has written both the mode register and the stack page register after reset.

A strap input selects one of two configurations. In the microprocessor configuration the part always boots in expansion mode. In the microcontroller configuration it boots in single-chip mode, and software may switch it.

Top module: `sys_bus_ctrl`

## Requirements
- R1: In the microcontroller configuration (mpu_cfg_i=0), reset leaves slot 0 = 8'h00, slot 1 = 8'h00, slot 2 = 8'h0C and slot 3 = 8'h00 on reg_rdata_o. After reset ready_o is 1 and irq_o and nmi_o are 0.
- R2: In the microprocessor configuration (mpu_cfg_i=1), slot 0 resets to 8'h81 and its bit 7 (bus mode, 1 = expansion) ignores writes and stays 1. In the microcontroller configuration all eight bits of slot 0 are writable.
- R3: Slot 0 holds the bus mode in bit 7 (driving bus_exp_o) and the CPU mode in bit 6 (driving cpu_max_o). Bits 5..3 are plain read/write, and bits 2..0 are the chip-enable selects for pins 2..0.
- R4: In expansion mode, each ce_pad_o bit carries ce_strobe_i when its select is 1 and dc_data_i when it is 0. In single-chip mode every ce_pad_o bit carries dc_data_i, whatever the selects hold.
- R5: The stack page (slot 1, stack_page_o) is limited to 8'h27 in expansion mode and to 8'h00 in single-chip mode. A larger write value is clamped to that limit, and reads return the clamped value.
- R6: Slot 2 holds the bus-release enable in bit 7, the wait code in bits 6..4, the clock select in bit 3 (clk_sel_o), the high-speed oscillator enable in bit 2 (osc_hi_en_o) and two plain read/write bits in 1..0.
- R7: With bus release enabled, bus_req_o follows req_pad_i, port_in_o is 0 and grant_pad_o follows bus_grant_i. With it disabled, port_in_o follows req_pad_i, bus_req_o is 0 and grant_pad_o follows port_out_i.
- R8: A cycle with ext_start_i high while ready_o is 1 makes ready_o low for exactly 2·code consecutive cycles, starting the cycle after the strobe. Code 0 adds no low cycle, and a strobe that arrives during a stretch is ignored.
- R9: Register reads and writes never pull ready_o low.
- R10: Slot 3 reads 0 in bits 7..2. Its bits 1..0 are read/write, reset to 0 and drive aux_ctl_o.
- R11: irq_o and nmi_o stay 0 until both slot 0 and slot 1 have been written since reset, in either order. From the cycle after the second of those writes, they pass irq_i and nmi_i. Only reset closes the gate again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mpu_cfg_i | input | 1 | Configuration strap, 1 = microprocessor |
| reg_sel_i | input | 2 | Register slot select |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data of the selected slot |
| bus_exp_o | output | 1 | Expansion mode active |
| cpu_max_o | output | 1 | CPU maximum mode |
| ce_strobe_i | input | 3 | Chip-enable strobes from the address decoder |
| dc_data_i | input | 3 | DC output data for the shared pins |
| ce_pad_o | output | 3 | Shared chip-enable/DC pins |
| stack_page_o | output | 8 | Effective stack page |
| clk_sel_o | output | 1 | CPU clock select |
| osc_hi_en_o | output | 1 | High-speed oscillator enable |
| aux_ctl_o | output | 2 | Slot 3 control bits |
| req_pad_i | input | 1 | Shared bus-request/input pin |
| port_in_o | output | 1 | Input port value |
| bus_req_o | output | 1 | Bus request to the CPU |
| bus_grant_i | input | 1 | Bus grant from the CPU |
| port_out_i | input | 1 | Output port value |
| grant_pad_o | output | 1 | Shared bus-grant/output pin |
| ext_start_i | input | 1 | External access start strobe |
| ready_o | output | 1 | Bus ready, low during wait states |
| irq_i | input | 4 | Maskable interrupt requests |
| nmi_i | input | 1 | Non-maskable interrupt request |
| irq_o | output | 4 | Gated interrupt requests |
| nmi_o | output | 1 | Gated non-maskable request |

## Verification
On every cycle, the assertions check several invariants. The gate never opens without both write flags set, and it never closes again. No interrupt passes while it is shut. The stack page stays within its limit, the bus-mode bit stays at 1 in the microprocessor configuration, and the shared pins carry DC data in single-chip mode. The wait counter only ever counts down or stays idle. Only the bench's scenarios can show other facts: the exact length of each stretch for several codes, that a repeated strobe does not lengthen it, the reset values, the field positions seen through reads, and that both write orders open the gate exactly one cycle late.

// File: rtl/busctl_pkg.sv
package busctl_pkg;
  localparam int DW = 8;

  typedef enum logic [1:0] {
    SLOT_MODE   = 2'd0,
    SLOT_STACK  = 2'd1,
    SLOT_SYSCLK = 2'd2,
    SLOT_AUX    = 2'd3
  } slot_e;

  localparam logic [DW-1:0] MODE_RST_MCU = 8'h00;
  localparam logic [DW-1:0] MODE_RST_MPU = 8'h81;
  localparam logic [DW-1:0] SYSCLK_RST   = 8'h0C;
  localparam logic [DW-1:0] PAGE_TOP_EXP = 8'h27;

  // bit positions inside slot 0
  localparam int MODE_BUS_BIT = 7;
  localparam int MODE_CPU_BIT = 6;
  // bit positions inside slot 2
  localparam int SC_REL_BIT   = 7;
  localparam int SC_WAIT_HI   = 6;
  localparam int SC_WAIT_LO   = 4;
  localparam int SC_CLK_BIT   = 3;
  localparam int SC_OSC_BIT   = 2;

  // highest stack page allowed for the current bus mode
  function automatic logic [DW-1:0] page_limit(input logic expansion);
    return expansion ? PAGE_TOP_EXP : '0;
  endfunction

  function automatic logic [DW-1:0] clamp_page(input logic [DW-1:0] v,
                                               input logic expansion);
    logic [DW-1:0] lim;
    lim = page_limit(expansion);
    return (v > lim) ? lim : v;
  endfunction

  // wait code n inserts 2*n states
  function automatic logic [3:0] wait_len(input logic [2:0] code);
    return {code, 1'b0};
  endfunction
endpackage

// File: rtl/busctl_regs.sv
module busctl_regs
  import busctl_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mpu_cfg,
  input  logic [1:0]    sel,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic [DW-1:0] mode_q,
  output logic [DW-1:0] page_eff,
  output logic [DW-1:0] sysclk_q,
  output logic [1:0]    aux_q,
  output logic          wr_mode_ev,
  output logic          wr_page_ev
);
  logic [DW-1:0] page_q;
  logic          exp_mode;

  assign exp_mode   = mode_q[MODE_BUS_BIT];
  assign wr_mode_ev = we && (slot_e'(sel) == SLOT_MODE);
  assign wr_page_ev = we && (slot_e'(sel) == SLOT_STACK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= mpu_cfg ? MODE_RST_MPU : MODE_RST_MCU;
    end else if (wr_mode_ev) begin
      mode_q <= {(mpu_cfg ? 1'b1 : wdata[MODE_BUS_BIT]), wdata[DW-2:0]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= '0;
    end else if (wr_page_ev) begin
      page_q <= clamp_page(wdata, exp_mode);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sysclk_q <= SYSCLK_RST;
    end else if (we && (slot_e'(sel) == SLOT_SYSCLK)) begin
      sysclk_q <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aux_q <= '0;
    end else if (we && (slot_e'(sel) == SLOT_AUX)) begin
      aux_q <= wdata[1:0];
    end
  end

  // a later switch to single-chip mode also pulls the page down
  assign page_eff = clamp_page(page_q, exp_mode);

  always_comb begin
    unique case (slot_e'(sel))
      SLOT_MODE:   rdata = mode_q;
      SLOT_STACK:  rdata = page_eff;
      SLOT_SYSCLK: rdata = sysclk_q;
      default:     rdata = {{(DW-2){1'b0}}, aux_q};
    endcase
  end

  // R2
  bus_mode_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mpu_cfg |-> mode_q[MODE_BUS_BIT]);

  // R5
  page_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (page_eff <= PAGE_TOP_EXP) && (exp_mode || page_eff == '0));

  // R10
  aux_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_e'(sel) == SLOT_AUX) |-> (rdata[DW-1:2] == '0));
endmodule

// File: rtl/busctl_wait.sv
module busctl_wait
  import busctl_pkg::*;
#(
  parameter int CW = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [2:0] code,
  output logic       ready
);
  logic [CW-1:0] cnt_q;
  logic          load_ev;

  assign ready   = (cnt_q == '0);
  assign load_ev = start && ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load_ev) begin
      cnt_q <= CW'(wait_len(code));
    end else if (!ready) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // R8
  zero_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_ev && code == 3'd0) |=> ready);

  // R8
  count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |=> (cnt_q == $past(cnt_q) - 1'b1));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !start) |=> ready);
endmodule

// File: rtl/busctl_irqgate.sv
module busctl_irqgate #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_mode_ev,
  input  logic         wr_page_ev,
  input  logic [N-1:0] irq_in,
  input  logic         nmi_in,
  output logic [N-1:0] irq_out,
  output logic         nmi_out
);
  logic seen_mode_q, seen_page_q, open_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_mode_q <= 1'b0;
      seen_page_q <= 1'b0;
      open_q      <= 1'b0;
    end else begin
      if (wr_mode_ev) seen_mode_q <= 1'b1;
      if (wr_page_ev) seen_page_q <= 1'b1;
      open_q <= seen_mode_q && seen_page_q;
    end
  end

  assign irq_out = irq_in & {N{open_q}};
  assign nmi_out = nmi_in & open_q;

  // R11
  open_needs_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(open_q) |-> $past(seen_mode_q && seen_page_q));

  // R11
  stays_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    open_q |=> open_q);

  // R11
  shut_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !open_q |-> (!nmi_out && irq_out == '0));
endmodule

// File: rtl/sys_bus_ctrl.sv
module sys_bus_ctrl
  import busctl_pkg::*;
#(
  parameter int IRQ_N = 4,
  parameter int CE_N  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mpu_cfg_i,
  input  logic [1:0]       reg_sel_i,
  input  logic             reg_we_i,
  input  logic [7:0]       reg_wdata_i,
  output logic [7:0]       reg_rdata_o,
  output logic             bus_exp_o,
  output logic             cpu_max_o,
  input  logic [CE_N-1:0]  ce_strobe_i,
  input  logic [CE_N-1:0]  dc_data_i,
  output logic [CE_N-1:0]  ce_pad_o,
  output logic [7:0]       stack_page_o,
  output logic             clk_sel_o,
  output logic             osc_hi_en_o,
  output logic [1:0]       aux_ctl_o,
  input  logic             req_pad_i,
  output logic             port_in_o,
  output logic             bus_req_o,
  input  logic             bus_grant_i,
  input  logic             port_out_i,
  output logic             grant_pad_o,
  input  logic             ext_start_i,
  output logic             ready_o,
  input  logic [IRQ_N-1:0] irq_i,
  input  logic             nmi_i,
  output logic [IRQ_N-1:0] irq_o,
  output logic             nmi_o
);
  logic [DW-1:0] mode_q, sysclk_q;
  logic          wr_mode_ev, wr_page_ev;
  logic          rel_en;

  busctl_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .mpu_cfg    (mpu_cfg_i),
    .sel        (reg_sel_i),
    .we         (reg_we_i),
    .wdata      (reg_wdata_i),
    .rdata      (reg_rdata_o),
    .mode_q     (mode_q),
    .page_eff   (stack_page_o),
    .sysclk_q   (sysclk_q),
    .aux_q      (aux_ctl_o),
    .wr_mode_ev (wr_mode_ev),
    .wr_page_ev (wr_page_ev)
  );

  busctl_wait #(.CW(4)) u_wait (
    .clk   (clk),
    .rst_n (rst_n),
    .start (ext_start_i),
    .code  (sysclk_q[SC_WAIT_HI:SC_WAIT_LO]),
    .ready (ready_o)
  );

  busctl_irqgate #(.N(IRQ_N)) u_gate (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_mode_ev (wr_mode_ev),
    .wr_page_ev (wr_page_ev),
    .irq_in     (irq_i),
    .nmi_in     (nmi_i),
    .irq_out    (irq_o),
    .nmi_out    (nmi_o)
  );

  assign bus_exp_o   = mode_q[MODE_BUS_BIT];
  assign cpu_max_o   = mode_q[MODE_CPU_BIT];
  assign clk_sel_o   = sysclk_q[SC_CLK_BIT];
  assign osc_hi_en_o = sysclk_q[SC_OSC_BIT];
  assign rel_en      = sysclk_q[SC_REL_BIT];

  // shared chip-enable / DC pins
  for (genvar g = 0; g < CE_N; g++) begin : g_ce_pin
    logic ce_on;
    assign ce_on       = bus_exp_o && mode_q[g];
    assign ce_pad_o[g] = ce_on ? ce_strobe_i[g] : dc_data_i[g];
  end

  // bus-release pin pair
  assign bus_req_o   = rel_en & req_pad_i;
  assign port_in_o   = ~rel_en & req_pad_i;
  assign grant_pad_o = rel_en ? bus_grant_i : port_out_i;

  // R4
  single_chip_dc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_exp_o |-> (ce_pad_o == dc_data_i));

  // R9
  reg_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_o && !ext_start_i) |=> ready_o);
endmodule

// File: tb/tb_sys_bus_ctrl.sv
module tb_sys_bus_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mpu_cfg_i = 1'b0;
  logic [1:0] reg_sel_i = '0;
  logic       reg_we_i = 1'b0;
  logic [7:0] reg_wdata_i = '0;
  logic [7:0] reg_rdata_o;
  logic       bus_exp_o, cpu_max_o;
  logic [2:0] ce_strobe_i = '0, dc_data_i = '0, ce_pad_o;
  logic [7:0] stack_page_o;
  logic       clk_sel_o, osc_hi_en_o;
  logic [1:0] aux_ctl_o;
  logic       req_pad_i = 1'b0, port_in_o, bus_req_o;
  logic       bus_grant_i = 1'b0, port_out_i = 1'b0, grant_pad_o;
  logic       ext_start_i = 1'b0, ready_o;
  logic [3:0] irq_i = '0, irq_o;
  logic       nmi_i = 1'b0, nmi_o;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  sys_bus_ctrl dut (
    .clk(clk), .rst_n(rst_n), .mpu_cfg_i(mpu_cfg_i),
    .reg_sel_i(reg_sel_i), .reg_we_i(reg_we_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .bus_exp_o(bus_exp_o), .cpu_max_o(cpu_max_o),
    .ce_strobe_i(ce_strobe_i), .dc_data_i(dc_data_i), .ce_pad_o(ce_pad_o),
    .stack_page_o(stack_page_o), .clk_sel_o(clk_sel_o),
    .osc_hi_en_o(osc_hi_en_o), .aux_ctl_o(aux_ctl_o),
    .req_pad_i(req_pad_i), .port_in_o(port_in_o), .bus_req_o(bus_req_o),
    .bus_grant_i(bus_grant_i), .port_out_i(port_out_i),
    .grant_pad_o(grant_pad_o), .ext_start_i(ext_start_i), .ready_o(ready_o),
    .irq_i(irq_i), .nmi_i(nmi_i), .irq_o(irq_o), .nmi_o(nmi_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic mpu);
    rst_n = 1'b0;
    mpu_cfg_i = mpu;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk);
    reg_sel_i = s; reg_wdata_i = d; reg_we_i = 1'b1;
    @(negedge clk);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [7:0] d);
    reg_sel_i = s;
    #1 d = reg_rdata_o;
  endtask

  task automatic t_reset_mcu();
    logic [7:0] v;
    do_reset(1'b0);
    rd(2'd0, v); chk("R1 slot0", v, 8'h00);
    rd(2'd1, v); chk("R1 slot1", v, 8'h00);
    rd(2'd2, v); chk("R1 slot2", v, 8'h0C);
    rd(2'd3, v); chk("R1 slot3", v, 8'h00);
    chk("R1 ready", ready_o, 1);
    irq_i = 4'hF; nmi_i = 1'b1;
    #1 chk("R1 irq gated", {nmi_o, irq_o}, 0);
  endtask

  task automatic t_gate_and_single_chip();
    logic [7:0] v;
    // slot 0 written alone: gate must stay shut; single-chip CE ignored
    wr(2'd0, 8'h7F);
    rd(2'd0, v); chk("R3 slot0 rw", v, 8'h7F);
    chk("R3 cpu mode", cpu_max_o, 1);
    chk("R3 bus mode", bus_exp_o, 0);
    ce_strobe_i = 3'b111; dc_data_i = 3'b010;
    #1 chk("R4 single-chip dc", ce_pad_o, 3'b010);
    repeat (3) @(negedge clk);
    chk("R11 one write shut", {nmi_o, irq_o}, 0);
    wr(2'd1, 8'h12);
    rd(2'd1, v); chk("R5 single-chip page", v, 8'h00);
    chk("R11 same cycle shut", nmi_o, 0);
    @(negedge clk);
    chk("R11 open nmi", nmi_o, 1);
    chk("R11 open irq", irq_o, 4'hF);
  endtask

  task automatic t_expansion();
    logic [7:0] v;
    wr(2'd0, 8'h85);
    ce_strobe_i = 3'b111; dc_data_i = 3'b000;
    #1 chk("R4 ce sel", ce_pad_o, 3'b101);
    ce_strobe_i = 3'b010; dc_data_i = 3'b111;
    #1 chk("R4 ce mix", ce_pad_o, 3'b010);
    wr(2'd1, 8'h30);
    rd(2'd1, v); chk("R5 clamp", v, 8'h27);
    wr(2'd1, 8'h15);
    rd(2'd1, v); chk("R5 in range", v, 8'h15);
    chk("R5 page out", stack_page_o, 8'h15);
    wr(2'd1, 8'h27);
    chk("R5 top page", stack_page_o, 8'h27);
  endtask

  task automatic t_sysclk();
    logic [7:0] v;
    wr(2'd2, 8'h78);
    rd(2'd2, v); chk("R6 read", v, 8'h78);
    chk("R6 clk sel", clk_sel_o, 1);
    chk("R6 osc", osc_hi_en_o, 0);
    wr(2'd2, 8'h07);
    rd(2'd2, v); chk("R6 low bits", v, 8'h07);
    chk("R6 osc on", osc_hi_en_o, 1);
    req_pad_i = 1'b1; bus_grant_i = 1'b1; port_out_i = 1'b0;
    #1 chk("R7 off req", {bus_req_o, port_in_o, grant_pad_o}, 3'b010);
    wr(2'd2, 8'h8C);
    chk("R7 on req", {bus_req_o, port_in_o, grant_pad_o}, 3'b101);
    bus_grant_i = 1'b0; req_pad_i = 1'b0;
    #1 chk("R7 on low", {bus_req_o, port_in_o, grant_pad_o}, 3'b000);
  endtask

  task automatic run_wait(input logic [2:0] code, input int hold, input int exp);
    int n = 0;
    wr(2'd2, {1'b0, code, 4'b1100});
    ext_start_i = 1'b1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (i == hold - 1) ext_start_i = 1'b0;
      if (!ready_o) n++;
    end
    chk($sformatf("R8 wait code %0d", code), n, exp);
  endtask

  task automatic t_wait();
    int lows = 0;
    run_wait(3'd0, 1, 0);
    run_wait(3'd1, 1, 2);
    run_wait(3'd3, 1, 6);
    run_wait(3'd7, 1, 14);
    run_wait(3'd1, 2, 2);
    run_wait(3'd2, 3, 4);
    // register traffic alone never stalls
    for (int i = 0; i < 4; i++) begin
      wr(2'd3, 8'(i));
      if (!ready_o) lows++;
    end
    chk("R9 reg access no stall", lows, 0);
  endtask

  task automatic t_aux();
    logic [7:0] v;
    wr(2'd3, 8'hFE);
    rd(2'd3, v); chk("R10 read", v, 8'h02);
    chk("R10 out", aux_ctl_o, 2'b10);
  endtask

  task automatic t_mpu();
    logic [7:0] v;
    do_reset(1'b1);
    rd(2'd0, v); chk("R2 reset", v, 8'h81);
    irq_i = 4'h5; nmi_i = 1'b1;
    // reverse order: page first
    wr(2'd1, 8'h40);
    rd(2'd1, v); chk("R5 mpu clamp", v, 8'h27);
    chk("R11 page only shut", nmi_o, 0);
    wr(2'd0, 8'h00);
    rd(2'd0, v); chk("R2 bus bit kept", v, 8'h80);
    chk("R11 rev same cycle", nmi_o, 0);
    @(negedge clk);
    chk("R11 rev open", {nmi_o, irq_o}, 5'h15);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset_mcu();
    t_gate_and_single_chip();
    t_expansion();
    t_sysclk();
    t_wait();
    t_aux();
    t_mpu();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule